// File: doc/BRIEF.md
# Slotted Response Transmitter

This block sends a tag-to-reader reply by switching a subcarrier-modulate enable on and off in fixed-length bit slots. It never starts on request: every reply is placed at a fixed distance after the moment the reader's last frame ended. The block takes that moment as a timestamp from the receive side, together with a free-running timestamp that counts subcarrier ticks. A normal data reply waits 70 ticks after the reader frame end. A write acknowledge waits 758 ticks.

While it waits, the block steps an external keystream generator so that the keystream is in the right position when the first bit goes out. For a data reply it then XORs each bit with the keystream bit and steps the generator once per bit. An acknowledge is a single one bit, sent without the keystream, and the generator is still stepped once for it. When the reply is over, the modulate enable drops to low, a one-cycle done pulse is raised, and the timestamp of the end of the last slot is presented. The next receive phase uses that timestamp as its reference.

Top module: `slot_resp_tx`

## Requirements
- R1: While reset is active and right after it, mod_en, busy, done and ks_step are low and tx_end_ts is zero.
- R2: A data reply presents bit 0 on mod_en from the clock edge at which tick is high and now_ts equals rx_end_ts + 70. mod_en changes only on edges at which tick is high. Each bit is held for 21 ticks.
- R3: Bits are sent least significant first, req_len bits in all. mod_en is 1 for a one bit and 0 for a zero bit.
- R4: In a data reply each bit sent equals req_word bit k XOR the value of ks_bit during the cycle in which ks_step is high for that bit. ks_step is high for exactly one cycle per bit.
- R5: Right after a request is accepted, ks_step is high on consecutive cycles, before the first bit: 2 cycles for a data reply and 35 for an acknowledge.
- R6: With req_ack = 1 the reply starts at rx_end_ts + 758. It is a single 1 bit, not XORed with ks_bit, and it is followed by exactly one ks_step. req_word and req_len are ignored.
- R7: mod_en keeps its level across the boundary between two slots that carry equal bits. It goes low at the edge that ends the last slot. done is high for exactly one cycle at that same edge, and busy is low from then on.
- R8: tx_end_ts equals rx_end_ts + gap + 21 × (bits sent), where gap is 70 or 758. It changes only in the cycle in which done is high.
- R9: A request made while busy is high is ignored. The reply in progress and the keystream steps are unchanged, and no further reply follows.
- R10: A data request with req_len = 0 or req_len > 16 is ignored. busy stays low and ks_step is not raised.
- R11: The deadline comparison is correct across a wrap of the timestamp. A reply whose deadline wraps past zero waits for that deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Subcarrier-rate enable; now_ts advances after each cycle in which it is high |
| now_ts | input | 32 | Current tick timestamp |
| rx_end_ts | input | 32 | Timestamp at which the reader frame ended; sampled on request |
| req | input | 1 | Start request |
| req_word | input | 16 | Reply data, bit 0 sent first |
| req_len | input | 5 | Number of data bits, 1 to 16 |
| req_ack | input | 1 | 1 selects a write acknowledge, 0 a data reply |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Keystream step strobe, one step per cycle high |
| mod_en | output | 1 | Subcarrier modulate enable |
| busy | output | 1 | A reply is pending or in progress |
| done | output | 1 | One-cycle pulse when the last slot ends |
| tx_end_ts | output | 32 | Timestamp of the end of the last slot sent |

## Verification
mod_en changes one register after the tick edge that meets a slot deadline. The bench therefore rebuilds, at every falling edge, the last timestamp the design has processed, from now_ts and tick. It compares mod_en with the bit that a scoreboard item expects for that timestamp, so that slot starts are checked to the exact tick. The keystream steps are counted on rising edges, because that is when the generator moves, and the count is compared when done arrives. tx_end_ts and the low mod_en are checked in the falling edge of the cycle in which done is high. An ignored request is confirmed by watching busy on the next falling edge and the step count a few cycles later.

// File: rtl/rt_pkg.sv
package rt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_WAIT = 2'd2,
      ST_SLOT = 2'd3
   } rt_state_e;
endpackage

// File: rtl/rt_deadline.sv
// Slot deadline register with a selectable reached-comparison variant.
module rt_deadline #(
   parameter int TS_W      = 32,
   parameter int STEP      = 21,
   parameter bit WRAP_SAFE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TS_W-1:0] base,
   input  logic [TS_W-1:0] offset,
   input  logic            advance,
   input  logic [TS_W-1:0] now,
   output logic [TS_W-1:0] deadline,
   output logic            reached
);
   localparam logic [TS_W-1:0] STEP_V = TS_W'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("rt_deadline: STEP must be positive");
   end
   if (TS_W < 8) begin : g_bad_ts
      $error("rt_deadline: TS_W too narrow");
   end

   logic [TS_W-1:0] dl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       dl_q <= '0;
      else if (load)    dl_q <= base + offset;
      else if (advance) dl_q <= dl_q + STEP_V;
   end

   assign deadline = dl_q;

   if (WRAP_SAFE) begin : g_wrap
      logic [TS_W-1:0] diff;
      assign diff    = now - dl_q;
      assign reached = ~diff[TS_W-1];
   end else begin : g_plain
      assign reached = (now >= dl_q);
   end
endmodule

// File: rtl/rt_shifter.sv
// Holds the reply bits and the number of bits still to send.
module rt_shifter #(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic [LEN_W-1:0]  len,
   input  logic              shift,
   output logic              cur_bit,
   output logic              empty
);
   if (DATA_W < 1) begin : g_bad_w
      $error("rt_shifter: DATA_W must be positive");
   end
   if ((1 << LEN_W) <= DATA_W) begin : g_bad_len
      $error("rt_shifter: LEN_W cannot hold DATA_W");
   end

   logic [DATA_W-1:0] sh_q;
   logic [LEN_W-1:0]  rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         rem_q <= '0;
      end else if (load) begin
         sh_q  <= word;
         rem_q <= len;
      end else if (shift) begin
         sh_q  <= sh_q >> 1;
         rem_q <= rem_q - LEN_W'(1);
      end
   end

   assign cur_bit = sh_q[0];
   assign empty   = (rem_q == '0);
endmodule

// File: rtl/rt_precount.sv
// Down counter that paces the keystream pre-advance, one step per clock.
module rt_precount #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= value;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/slot_resp_tx.sv
module slot_resp_tx #(
   parameter int TS_W       = 32,
   parameter int DATA_W     = 16,
   parameter int SLOT_TICKS = 21,
   parameter int DATA_GAP   = 70,
   parameter int ACK_GAP    = 758,
   parameter bit WRAP_SAFE  = 1'b1,
   localparam int LEN_W     = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TS_W-1:0]   now_ts,
   input  logic [TS_W-1:0]   rx_end_ts,
   input  logic              req,
   input  logic [DATA_W-1:0] req_word,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_ack,
   input  logic              ks_bit,
   output logic              ks_step,
   output logic              mod_en,
   output logic              busy,
   output logic              done,
   output logic [TS_W-1:0]   tx_end_ts
);
   import rt_pkg::*;

   localparam int DATA_PRE = DATA_GAP / SLOT_TICKS - 1;
   localparam int ACK_PRE  = ACK_GAP / SLOT_TICKS - 1;
   localparam int PRE_MAX  = (ACK_PRE > DATA_PRE) ? ACK_PRE : DATA_PRE;
   localparam int PRE_W    = $clog2(PRE_MAX + 1);

   if (DATA_PRE < 1 || ACK_PRE < 1) begin : g_bad_gap
      $error("slot_resp_tx: each gap must span at least two slots");
   end

   rt_state_e state_q;
   logic      xor_en_q, mod_q, done_q;
   logic [TS_W-1:0] end_q;

   logic len_ok, accept, reached, slot_hit, bit_load, finish, pre_last;
   logic sh_bit, sh_empty;
   logic [TS_W-1:0] deadline, gap_off;
   logic [DATA_W-1:0] load_word;
   logic [LEN_W-1:0]  load_len;
   logic [PRE_W-1:0]  pre_val;

   assign len_ok    = (req_len != '0) && (req_len <= LEN_W'(DATA_W));
   assign accept    = req && (state_q == ST_IDLE) && (req_ack || len_ok);
   assign gap_off   = req_ack ? TS_W'(ACK_GAP) : TS_W'(DATA_GAP);
   assign pre_val   = req_ack ? PRE_W'(ACK_PRE) : PRE_W'(DATA_PRE);
   assign load_word = req_ack ? DATA_W'(1) : req_word;
   assign load_len  = req_ack ? LEN_W'(1) : req_len;

   assign slot_hit  = tick && reached;
   assign bit_load  = slot_hit && ((state_q == ST_WAIT) ||
                                   ((state_q == ST_SLOT) && !sh_empty));
   assign finish    = slot_hit && (state_q == ST_SLOT) && sh_empty;
   assign ks_step   = (state_q == ST_PRE) || bit_load;

   rt_deadline #(.TS_W(TS_W), .STEP(SLOT_TICKS), .WRAP_SAFE(WRAP_SAFE)) u_dl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .base     (rx_end_ts),
      .offset   (gap_off),
      .advance  (bit_load),
      .now      (now_ts),
      .deadline (deadline),
      .reached  (reached)
   );

   rt_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .word    (load_word),
      .len     (load_len),
      .shift   (bit_load),
      .cur_bit (sh_bit),
      .empty   (sh_empty)
   );

   rt_precount #(.CNT_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .value (pre_val),
      .last  (pre_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         xor_en_q <= 1'b0;
         mod_q    <= 1'b0;
         done_q   <= 1'b0;
         end_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q  <= ST_PRE;
               xor_en_q <= !req_ack;
            end
            ST_PRE:  if (pre_last) state_q <= ST_WAIT;
            ST_WAIT: if (bit_load) begin
               mod_q   <= sh_bit ^ (xor_en_q & ks_bit);
               state_q <= ST_SLOT;
            end
            ST_SLOT: begin
               if (bit_load) begin
                  mod_q <= sh_bit ^ (xor_en_q & ks_bit);
               end else if (finish) begin
                  mod_q   <= 1'b0;
                  done_q  <= 1'b1;
                  end_q   <= deadline;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mod_en    = mod_q;
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign tx_end_ts = end_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
   parameter int TS_W   = 32,
   parameter int DATA_W = 16,
   parameter int LEN_W  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             req,
   input logic             req_ack,
   input logic [LEN_W-1:0] req_len,
   input logic             ks_step,
   input logic             mod_en,
   input logic             busy,
   input logic             done,
   input logic [TS_W-1:0]  tx_end_ts
);
   // R2: the modulate level moves only after a tick edge
   p_mod_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en != $past(mod_en)) |-> $past(tick));

   // R7: no modulation while idle
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mod_en);

   // R7: done lasts one cycle and closes a busy period
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8: the end timestamp only moves with done
   p_end_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(tx_end_ts));

   // R4: keystream steps only during a reply
   p_step_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ks_step |-> busy);

   // R10: a bad data length does not start a reply
   p_bad_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req && !req_ack &&
       ((req_len == '0) || (req_len > LEN_W'(DATA_W)))) |=> !busy);
endmodule

bind slot_resp_tx rt_checker #(.TS_W(TS_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .req       (req),
   .req_ack   (req_ack),
   .req_len   (req_len),
   .ks_step   (ks_step),
   .mod_en    (mod_en),
   .busy      (busy),
   .done      (done),
   .tx_end_ts (tx_end_ts)
);

// File: tb/slot_resp_tx_test.sv
module slot_resp_tx_test;
   localparam int SLOT = 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [31:0] now_ts = 32'h100;
   logic [31:0] rx_end_ts = '0;
   logic        req = 1'b0;
   logic [15:0] req_word = '0;
   logic [4:0]  req_len = '0;
   logic        req_ack = 1'b0;
   logic        ks_bit, ks_step, mod_en, busy, done;
   logic [31:0] tx_end_ts;

   always #10 clk = ~clk;

   slot_resp_tx uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .now_ts(now_ts),
      .rx_end_ts(rx_end_ts), .req(req), .req_word(req_word),
      .req_len(req_len), .req_ack(req_ack), .ks_bit(ks_bit),
      .ks_step(ks_step), .mod_en(mod_en), .busy(busy), .done(done),
      .tx_end_ts(tx_end_ts)
   );

   typedef struct {
      logic [31:0] dl;
      int          nbits;
      logic [15:0] bits;
      int          steps;
   } item_t;

   item_t q[$];
   item_t cur;
   bit    cur_v = 1'b0;
   int    checks = 0, errors = 0;
   int    step_total = 0, step_base = 0, trace_bad = 0;
   logic [15:0] lfsr;
   bit    ts_set = 1'b0;
   logic [31:0] ts_val;
   int    phase = 0;

   function automatic logic [15:0] lfsr_nx(input logic [15:0] s);
      return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
   endfunction

   // keystream generator outside the block
   always @(posedge clk) begin
      if (!rst_n) lfsr <= 16'hACE1;
      else if (ks_step) begin
         lfsr <= lfsr_nx(lfsr);
         step_total++;
      end
   end
   assign ks_bit = lfsr[0];

   task automatic check(input bit ok, input string rq, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
      end
   endtask

   // monitor first, then input update, in one falling-edge process
   initial begin
      forever begin
         @(negedge clk);
         if (cur_v) begin
            logic [31:0] last_t, diff;
            logic        expb;
            last_t = tick ? now_ts : now_ts - 32'd1;
            diff   = last_t - cur.dl;
            expb   = (diff < 32'(cur.nbits * SLOT)) ? cur.bits[int'(diff) / SLOT] : 1'b0;
            if (mod_en !== expb) trace_bad++;
            if (done) begin
               check(trace_bad == 0, "R2/R3/R4/R7 slot trace", trace_bad, 0);
               check(tx_end_ts == cur.dl + 32'(cur.nbits * SLOT), "R8 end timestamp",
                     tx_end_ts, cur.dl + 32'(cur.nbits * SLOT));
               check(step_total - step_base == cur.steps, "R4/R5 keystream steps",
                     step_total - step_base, cur.steps);
               check(!mod_en && !busy, "R7 low after last slot", {mod_en, busy}, 0);
               cur_v = 1'b0;
            end
         end else begin
            if (done) check(1'b0, "R9 unexpected done", 1, 0);
            if (busy && q.size() > 0) begin
               cur = q.pop_front();
               cur_v = 1'b1;
               trace_bad = 0;
               step_base = step_total;
            end
         end
         if (ts_set) begin
            now_ts = ts_val;
            ts_set = 1'b0;
         end else if (tick) now_ts = now_ts + 32'd1;
         tick  = (phase == 0);
         phase = (phase + 1) % 3;
      end
   end

   task automatic send(input logic [15:0] w, input int n, input bit ack,
                       input logic [31:0] rx_end, input bit expect_start);
      @(negedge clk);
      if (expect_start) begin
         item_t it;
         logic [15:0] s;
         int pre, nb;
         s   = lfsr;
         pre = ack ? 35 : 2;
         nb  = ack ? 1 : n;
         repeat (pre) s = lfsr_nx(s);
         it.bits = '0;
         for (int k = 0; k < nb; k++) begin
            it.bits[k] = ack ? 1'b1 : (w[k] ^ s[0]);
            s = lfsr_nx(s);
         end
         it.dl    = rx_end + (ack ? 32'd758 : 32'd70);
         it.nbits = nb;
         it.steps = pre + nb;
         q.push_back(it);
      end
      req = 1'b1; req_word = w; req_len = n[4:0]; req_ack = ack; rx_end_ts = rx_end;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || cur_v || q.size() > 0) @(negedge clk);
   endtask

   task automatic expect_quiet(input string rq);
      int s0;
      s0 = step_total;
      check(!busy, rq, busy, 0);
      repeat (10) begin
         @(negedge clk);
         if (busy) check(1'b0, rq, busy, 0);
      end
      check(step_total == s0, rq, step_total - s0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!mod_en && !busy && !done && !ks_step, "R1 outputs in reset",
            {mod_en, busy, done, ks_step}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mod_en && !busy && !done && tx_end_ts == 0, "R1 after reset",
            {mod_en, busy, done}, 0);

      // R2 R3 R4: short data reply
      send(16'h002B, 6, 1'b0, now_ts - 32'd3, 1'b1);
      wait_idle();
      // R3: twelve-bit reply
      send(16'h0A5C, 12, 1'b0, now_ts, 1'b1);
      wait_idle();
      // R7: full width of ones, equal neighbours hold across boundaries
      send(16'hFFFF, 16, 1'b0, now_ts + 32'd4, 1'b1);
      wait_idle();
      // R3: single-bit reply
      send(16'h0001, 1, 1'b0, now_ts, 1'b1);
      wait_idle();
      // R6: acknowledge with junk word and zero length
      send(16'h0000, 0, 1'b1, now_ts - 32'd2, 1'b1);
      wait_idle();

      // R9: request during a reply is ignored
      send(16'h0133, 9, 1'b0, now_ts, 1'b1);
      repeat (20) @(negedge clk);
      req = 1'b1; req_word = 16'hFFFF; req_len = 5'd3; req_ack = 1'b1;
      rx_end_ts = now_ts;
      @(negedge clk);
      req = 1'b0;
      wait_idle();
      expect_quiet("R9 no reply after ignored request");

      // R10: bad lengths ignored
      send(16'h00FF, 0, 1'b0, now_ts, 1'b0);
      expect_quiet("R10 zero length ignored");
      send(16'h00FF, 17, 1'b0, now_ts, 1'b0);
      expect_quiet("R10 oversize length ignored");

      // R11: deadline wraps past zero
      ts_val = 32'hFFFF_FFE0;
      ts_set = 1'b1;
      repeat (3) @(negedge clk);
      send(16'h0015, 5, 1'b0, 32'hFFFF_FFF0, 1'b1);
      @(negedge clk);
      check(busy && !mod_en, "R11 waits across wrap", {busy, mod_en}, 2);
      wait_idle();
      // R6: acknowledge after a wrap
      send(16'h1234, 7, 1'b1, now_ts, 1'b1);
      wait_idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule